// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side DMA engine of an Ethernet MAC. Frame bytes arrive one per cycle on a byte stream with a valid/ready handshake and an end-of-frame marker. The block places them in memory buffers that are described by a ring of two-word descriptors. The ring starts at a programmed queue base. For each buffer the block reads the descriptor's address word. It packs the bytes into 32-bit words and writes them to the buffer. It then writes a status word that holds the byte count and the first/last-buffer flags. Last, it writes the address word back with its used flag set, which passes ownership to software.

Software recycles a buffer by clearing the used flag. A frame longer than one buffer continues in the following descriptors. When the block meets a descriptor that is still in use, it discards the rest of the frame, pulses a resource-error output and stays on that descriptor, so the next frame tries it again. The block never skips a descriptor. The memory side is a plain word-wide port with one access per cycle and one cycle of read latency.

Top module: `rxd_ring_writer`

## Requirements
- R1: During and after reset, with no frame pending, rx_ready, mem_rd, mem_wr and res_err are all low.
- R2: While rx_enable is low and the block is idle, the ring pointer follows queue_base. The first byte of a frame with rx_enable high causes a read of the address word at the ring pointer.
- R3: The bytes of a buffer are written little-endian (the byte at position k of the buffer goes to bits 8*(k%4)+7:8*(k%4) of word k/4) to consecutive words starting at the buffer address, which is address-word bits 31:2 followed by two zero bits. Unused byte lanes of the final word are zero.
- R4: The status word, at descriptor address + 4, holds the buffer's byte count in bits 13:0, the first-buffer-of-frame flag in bit 14 and the last-buffer-of-frame flag in bit 15, with every other bit zero. It is written in the cycle before the address word.
- R5: The address word is written back with bits 31:1 unchanged and bit 0 (used) set.
- R6: After a buffer is handed over, the next descriptor is the one 8 bytes further on, or queue_base if bit 1 (wrap) of the address word was set.
- R7: A frame longer than BUF_BYTES fills buffers of BUF_BYTES each and continues in the following descriptors. Only the first of these buffers has bit 14 set, and only the last has bit 15 set.
- R8: If the fetched address word has bit 0 set, the remaining bytes of the frame are accepted and discarded with no memory write, res_err pulses for one cycle, and the ring pointer stays on that descriptor.
- R9: A frame that starts while rx_enable is low is accepted and discarded without any memory access or res_err. Enabling again restarts the ring at queue_base.
- R10: The memory port never reads and writes in the same cycle, and every address is word aligned. Read data is taken one cycle after mem_rd.
- R11: The byte count in every status word is between 1 and BUF_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Receive enable; frames starting while low are discarded |
| queue_base | input | 32 | Byte address of the first descriptor, 8-byte aligned |
| rx_valid | input | 1 | A frame byte is present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | This byte ends the frame |
| rx_ready | output | 1 | Byte is taken at this edge when rx_valid is high |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| res_err | output | 1 | One-cycle pulse when a frame meets a descriptor still in use |

## Verification
The assertions assume that the memory returns read data exactly one cycle after a read request and never stalls. They also assume that queue_base stays constant while rx_enable is high, and that ring descriptors sit at 8-byte-aligned addresses. The bench's memory model returns registered read data with fixed latency. It changes queue_base only at reset. It changes descriptors (recycling) only between frames, while the block is idle. Frame lengths are drawn at random but stay below the total ring capacity, so each frame touches each descriptor at most once.

// File: rtl/rxd_pkg.sv
// Shared constants and types for the receive descriptor ring writer.
// Assumes 32-bit descriptor words and byte addresses.
package rxd_pkg;
    localparam int DESC_STRIDE = 8;   // two 32-bit words per descriptor
    localparam int STAT_OFS    = 4;   // status word follows address word
    localparam int LEN_W       = 14;  // byte-count field width
    localparam int USED_BIT    = 0;
    localparam int WRAP_BIT    = 1;
    localparam int SOF_BIT     = 14;
    localparam int EOF_BIT     = 15;

    typedef enum logic [2:0] {
        S_IDLE,   // waiting for a frame
        S_FETCH,  // read the address word
        S_DESC,   // read data returned, decide
        S_FILL,   // stream bytes into the buffer
        S_STAT,   // write the status word
        S_OWN,    // write the address word with used set
        S_DROP    // discard the rest of a frame
    } st_e;
endpackage

// File: rtl/rxd_packer.sv
// Byte-to-word packer. Gathers bytes little-endian into a 32-bit word.
// The output word combines the bytes already held with the current byte,
// so a flush can write in the same cycle as the byte arrives. After a
// flush the held lanes are cleared, so unused lanes of a partial word read zero.
module rxd_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  logic        flush,
    input  logic [1:0]  lane,
    input  logic [7:0]  din,
    output logic [31:0] word
);
    logic [31:0] hold;

    // Merge the current byte into its lane of the held word.
    always_comb begin
        word = hold;
        word[8*lane +: 8] = din;
    end

    // Keep partial words; clear once written out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= '0;
        else if (take)
            hold <= flush ? '0 : word;
    end
endmodule

// File: rtl/rxd_ring_ptr.sv
// Ring pointer. Holds the byte address of the current descriptor.
// It reloads the base on request and steps one descriptor, or back to the
// base when the wrap flag is set. The base is assumed 8-byte aligned.
module rxd_ring_ptr (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] base,
    input  logic        load,
    input  logic        adv,
    input  logic        wrap,
    output logic [31:0] ptr
);
    import rxd_pkg::*;

    // Pointer update: reset/load to base, else advance on hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            ptr <= base;
        else if (adv)
            ptr <= wrap ? base : ptr + 32'(DESC_STRIDE);
    end
endmodule

// File: rtl/rxd_ring_writer.sv
// Receive descriptor ring writer (top). It fetches a descriptor per buffer,
// streams frame bytes into the buffer, writes the status word and then
// the address word with the used flag set. It splits long frames over several
// descriptors and drops frames that meet a descriptor still in use.
// Assumes: memory read data arrives one cycle after mem_rd and the memory
// never stalls. BUF_BYTES is a multiple of 4 and fits the 14-bit count.
module rxd_ring_writer #(
    parameter int BUF_BYTES = 1536
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_enable,
    input  logic [31:0] queue_base,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic        rx_ready,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        res_err
);
    import rxd_pkg::*;

    localparam int CNT_W = $clog2(BUF_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BUF_BYTES);

    st_e              st, st_nx;
    logic [29:0]      buf_addr;
    logic             wrap_f;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic             sof_f, eof_f, cont_f;
    logic [31:0]      ptr;
    logic [31:0]      pk_word;
    logic [31:0]      stat_w;
    logic             take, flush, buf_full;
    logic             ptr_load, ptr_adv;

    assign cnt_nx   = cnt + 1'b1;
    assign buf_full = (cnt_nx == CNT_FULL);
    assign take     = (st == S_FILL) && rx_valid;
    assign flush    = take && ((cnt[1:0] == 2'd3) || rx_last || buf_full);
    assign ptr_load = (st == S_IDLE) && !rx_enable;
    assign ptr_adv  = (st == S_OWN);

    rxd_ring_ptr u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .base (queue_base),
        .load (ptr_load),
        .adv  (ptr_adv),
        .wrap (wrap_f),
        .ptr  (ptr)
    );

    rxd_packer u_pack (
        .clk  (clk),
        .rst_n(rst_n),
        .take (take),
        .flush(flush),
        .lane (cnt[1:0]),
        .din  (rx_data),
        .word (pk_word)
    );

    // Status word: count, first/last flags, all else zero.
    always_comb begin
        stat_w            = '0;
        stat_w[LEN_W-1:0] = LEN_W'(cnt);
        stat_w[SOF_BIT]   = sof_f;
        stat_w[EOF_BIT]   = eof_f;
    end

    // Next state and memory/handshake outputs.
    always_comb begin
        st_nx     = st;
        rx_ready  = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = '0;
        res_err   = 1'b0;
        case (st)
            S_IDLE: begin
                if (rx_valid)
                    st_nx = rx_enable ? S_FETCH : S_DROP;
            end
            S_FETCH: begin
                mem_rd = 1'b1;
                st_nx  = S_DESC;
            end
            S_DESC: begin
                if (mem_rdata[USED_BIT]) begin
                    res_err = 1'b1;
                    st_nx   = S_DROP;
                end else begin
                    st_nx = S_FILL;
                end
            end
            S_FILL: begin
                rx_ready  = 1'b1;
                mem_wr    = flush;
                mem_addr  = {buf_addr, 2'b00} + 32'({cnt[CNT_W-1:2], 2'b00});
                mem_wdata = pk_word;
                if (take && (rx_last || buf_full))
                    st_nx = S_STAT;
            end
            S_STAT: begin
                mem_wr    = 1'b1;
                mem_addr  = ptr + 32'(STAT_OFS);
                mem_wdata = stat_w;
                st_nx     = S_OWN;
            end
            S_OWN: begin
                mem_wr    = 1'b1;
                mem_wdata = {buf_addr, wrap_f, 1'b1};
                st_nx     = cont_f ? S_FETCH : S_IDLE;
            end
            S_DROP: begin
                rx_ready = 1'b1;
                if (rx_valid && rx_last)
                    st_nx = S_IDLE;
            end
            default: st_nx = S_IDLE;
        endcase
    end

    // State register and per-buffer context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            buf_addr <= '0;
            wrap_f   <= 1'b0;
            cnt      <= '0;
            sof_f    <= 1'b0;
            eof_f    <= 1'b0;
            cont_f   <= 1'b0;
        end else begin
            st <= st_nx;
            case (st)
                S_IDLE: begin
                    sof_f  <= 1'b1;
                    cont_f <= 1'b0;
                end
                S_DESC: begin
                    buf_addr <= mem_rdata[31:2];
                    wrap_f   <= mem_rdata[WRAP_BIT];
                    cnt      <= '0;
                end
                S_FILL: begin
                    if (take) begin
                        cnt <= cnt_nx;
                        if (rx_last) begin
                            eof_f  <= 1'b1;
                            cont_f <= 1'b0;
                        end else if (buf_full) begin
                            eof_f  <= 1'b0;
                            cont_f <= 1'b1;
                        end
                    end
                end
                S_OWN: sof_f <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxd_ring_writer_chk.sv
// Property checker for rxd_ring_writer, bound to every instance.
module rxd_ring_writer_chk #(
    parameter int BUF_BYTES = 1536
) (
    input logic           clk,
    input logic           rst_n,
    input rxd_pkg::st_e   st,
    input logic [31:0]    ptr,
    input logic [31:0]    queue_base,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic [31:0]    mem_addr,
    input logic [31:0]    mem_wdata,
    input logic [31:0]    mem_rdata,
    input logic           res_err
);
    import rxd_pkg::*;

    // R10: one access per cycle
    p_one_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R10: word-aligned addresses
    p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_addr[1:0] == 2'b00));

    // R4: status written just before the address word, at +4
    p_stat_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_OWN) |-> ($past(mem_wr) && ($past(mem_addr) == mem_addr + 32'd4)));

    // R5: hand-over write sets used
    p_used_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_OWN) |-> (mem_wr && mem_wdata[USED_BIT]));

    // R6: wrap returns to the base
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_OWN && mem_wdata[WRAP_BIT]) |=> (ptr == $past(queue_base)));

    // R6: otherwise step one descriptor
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_OWN && !mem_wdata[WRAP_BIT]) |=> (ptr == $past(ptr) + 32'd8));

    // R8: error only on a returned descriptor still in use
    p_err_used_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_err |-> ($past(mem_rd) && mem_rdata[USED_BIT]));

    // R8: error is a single-cycle pulse
    p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_err |=> !res_err);

    // R11: count within one buffer and nonzero
    p_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_STAT) |-> ((mem_wdata[LEN_W-1:0] != '0) &&
                            (32'(mem_wdata[LEN_W-1:0]) <= BUF_BYTES)));
endmodule

bind rxd_ring_writer rxd_ring_writer_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .ptr       (ptr),
    .queue_base(queue_base),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .res_err   (res_err)
);

// File: tb/rxd_ring_writer_tb.sv
module rxd_ring_writer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BUF  = 32;
    localparam int NDSC = 4;
    localparam logic [31:0] BASE = 32'h40;
    localparam logic [31:0] BUFS = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_enable = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_ready, mem_rd, mem_wr, res_err;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [0:255];
    logic        host_we = 1'b0;
    logic [31:0] host_a = '0, host_d = '0;
    logic [7:0]  fb [0:127];

    int nchk = 0, nerr = 0;
    int err_seen = 0, exp_err = 0, wr_cnt = 0, bad_acc = 0;
    logic [31:0] last_rd = '0;
    int  exp_idx = 0;
    bit  used [NDSC];
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxd_ring_writer #(.BUF_BYTES(BUF)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .queue_base(BASE),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_ready(rx_ready), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .res_err(res_err)
    );

    // Memory model with one cycle read latency, plus port monitors.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
        else if (host_we) mem[host_a[9:2]] <= host_d;
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[9:2]];
            last_rd   <= mem_addr;
        end
        if (rst_n) begin
            if (res_err) err_seen <= err_seen + 1;
            if (mem_wr) wr_cnt <= wr_cnt + 1;
            if ((mem_rd && mem_wr) || ((mem_rd || mem_wr) && mem_addr[1:0] != 2'b00))
                bad_acc <= bad_acc + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] desc_w0(input int i);
        return BUFS + 32'(i * BUF) + ((i == NDSC-1) ? 32'd2 : 32'd0);
    endfunction

    task automatic host_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); host_we = 1'b1; host_a = a; host_d = d;
        @(negedge clk); host_we = 1'b0;
    endtask

    task automatic recycle_all();
        for (int i = 0; i < NDSC; i++)
            if (used[i]) begin
                host_write(BASE + 32'(8*i), desc_w0(i));
                used[i] = 1'b0;
            end
    endtask

    task automatic drive_frame(input int len);
        for (int k = 0; k < len; k++) begin
            bit rdy;
            @(negedge clk);
            rx_valid = 1'b1; rx_data = fb[k]; rx_last = (k == len-1);
            rdy = rx_ready;
            @(posedge clk);
            while (!rdy) begin
                @(negedge clk);
                rdy = rx_ready;
                @(posedge clk);
            end
        end
        @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // Expected placement of the frame over the ring, compared with memory.
    task automatic check_frame(input int len);
        int rem = len, off = 0;
        bit first = 1'b1;
        while (rem > 0) begin
            int i = exp_idx;
            int chunk;
            logic [31:0] st_exp;
            if (used[i]) begin
                exp_err++;
                break;
            end
            chunk = (rem > BUF) ? BUF : rem;
            for (int w = 0; w < (chunk + 3) / 4; w++) begin
                logic [31:0] ew = '0;
                for (int b = 0; b < 4; b++)
                    if (4*w + b < chunk) ew[8*b +: 8] = fb[off + 4*w + b];
                chk(mem[(BUFS + 32'(i*BUF) + 32'(4*w)) >> 2] == ew, "R3 buffer word",
                    mem[(BUFS + 32'(i*BUF) + 32'(4*w)) >> 2], ew);
            end
            st_exp = 32'(chunk) | (first ? 32'h4000 : 32'h0) | ((rem == chunk) ? 32'h8000 : 32'h0);
            chk(mem[(BASE + 32'(8*i) + 32'd4) >> 2] == st_exp, "R4 R7 R11 status word",
                mem[(BASE + 32'(8*i) + 32'd4) >> 2], st_exp);
            chk(mem[(BASE + 32'(8*i)) >> 2] == (desc_w0(i) | 32'd1), "R5 address word",
                mem[(BASE + 32'(8*i)) >> 2], desc_w0(i) | 32'd1);
            used[i] = 1'b1;
            exp_idx = (i == NDSC-1) ? 0 : i + 1;
            off += chunk; rem -= chunk; first = 1'b0;
        end
        chk(err_seen == exp_err, "R8 resource error count", 32'(err_seen), 32'(exp_err));
    endtask

    task automatic run_frame(input int len);
        for (int k = 0; k < len; k++) fb[k] = 8'($urandom);
        drive_frame(len);
        check_frame(len);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int wr0, err0;
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < NDSC; i++) begin
            mem[(BASE + 32'(8*i)) >> 2] = desc_w0(i);
            used[i] = 1'b0;
        end
        rx_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk({rx_ready, mem_rd, mem_wr, res_err} == 4'b0, "R1 reset outputs",
            32'({rx_ready, mem_rd, mem_wr, res_err}), 32'd0);
        rx_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({rx_ready, mem_rd, mem_wr, res_err} == 4'b0, "R1 idle outputs",
            32'({rx_ready, mem_rd, mem_wr, res_err}), 32'd0);
        rx_enable = 1'b1;
        @(negedge clk);

        // Directed lengths: single word, partial word, exact buffer, wrap.
        run_frame(5);
        chk(last_rd == BASE, "R2 first fetch at base", last_rd, BASE);
        recycle_all();
        run_frame(1);
        chk(last_rd == BASE + 32'd8, "R2 R6 next descriptor fetch", last_rd, BASE + 32'd8);
        run_frame(4);
        run_frame(BUF);
        run_frame(7);
        chk(last_rd == BASE, "R6 wrap back to base", last_rd, BASE);
        recycle_all();
        run_frame(70);   // R7: three buffers
        recycle_all();

        // Random lengths with recycling.
        for (int n = 0; n < 12; n++) begin
            run_frame(1 + int'($urandom % 90));
            recycle_all();
        end

        // R8: ring full, frame dropped, pointer stays.
        for (int n = 0; n < NDSC; n++) run_frame(10);
        wr0 = wr_cnt;
        run_frame(20);
        chk(wr_cnt == wr0, "R8 no writes on drop", 32'(wr_cnt), 32'(wr0));
        recycle_all();
        run_frame(9);    // lands on the same descriptor as the dropped one
        recycle_all();

        // R8: descriptor in use met in the middle of a frame.
        host_write(BASE + 32'(8*((exp_idx + 1) % NDSC)), desc_w0((exp_idx + 1) % NDSC) | 32'd1);
        used[(exp_idx + 1) % NDSC] = 1'b1;
        run_frame(45);
        recycle_all();

        // R9: disabled frame discarded; enable restarts at base.
        rx_enable = 1'b0;
        @(negedge clk);
        wr0 = wr_cnt; err0 = err_seen;
        for (int k = 0; k < 12; k++) fb[k] = 8'($urandom);
        last_rd = 32'hFFFF_FFFF;
        drive_frame(12);
        chk(wr_cnt == wr0, "R9 no writes while disabled", 32'(wr_cnt), 32'(wr0));
        chk(err_seen == err0, "R9 no error while disabled", 32'(err_seen), 32'(err0));
        chk(last_rd == 32'hFFFF_FFFF, "R9 no reads while disabled", last_rd, 32'hFFFF_FFFF);
        rx_enable = 1'b1;
        @(negedge clk);
        exp_idx = 0;
        run_frame(6);
        chk(last_rd == BASE, "R9 restart at base", last_rd, BASE);

        chk(bad_acc == 0, "R10 memory port accesses", 32'(bad_acc), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule